// File: doc/BRIEF.md
# Floating-Point Status Register with Compare Queue

This block holds the 32-bit status and control word of a scalar floating-point unit. Software loads and reads the whole word. Two fields of the word are decoded continuously and driven to the arithmetic datapath: a 2-bit rounding-mode field, which becomes a one-hot rounding select, and a single flush control bit, which drives both the result flush-to-zero line and the operand flush-to-zero line.

Each completed operation presents a 5-bit exception vector. Any exceptions it reports are ORed into a sticky flag field. If a reported exception also has its enable bit set, the block raises a one-cycle assist trap.

Compare instructions supply a relation code from an external evaluator, a 5-bit condition mask and a 3-bit target index. The condition bit chosen by the relation is stored in one of two ways. A nonzero target writes it into a single compare slot. A zero target pushes the current condition bit into a right-shifting compare queue and then stores the new bit as the condition bit.

Top module: `fpsr_unit`

## Requirements
- R1: The rounding field at bits [10:9] drives `round_sel` one-hot as follows: code 0 (nearest even) gives bit 0, code 1 (toward zero) gives bit 1, code 2 (toward +infinity) gives bit 2, and code 3 (toward -infinity) gives bit 3.
- R2: Bit 5 of the word drives both `flush_result` and `flush_operand`.
- R3: The exception vector uses the order bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact. When `op_done` is high, the vector is ORed into the sticky flags at bits [31:27], in the same order. Flags are never cleared except by a software write.
- R4: An `op_done` with an all-zero vector leaves the word unchanged and raises no trap.
- R5: `assist_trap` is high for exactly one cycle, in the cycle after an operation reports an exception whose enable bit is set. The enable bits are at [4:0], in the same order as the flags. An operation that reports only disabled exceptions raises no trap.
- R6: For a compare with target y in the range 1 to 7, the selected condition bit is written to bit 21-(y-1), and no other bit of the word changes. Mask bit 4 is selected on relation 0 (greater), bit 3 on relation 1 (less), bit 2 on relation 2 (equal) and bit 1 on relation 3 (unordered).
- R7: For a compare with target 0, the queue at bits [25:15] shifts right by one place and its old bit 15 is lost. The old condition bit at bit 26 moves into queue head bit 25, and the new result is written to bit 26.
- R8: A software write loads the whole word in one cycle. It overrides any operation or compare in the same cycle, and no trap is raised for that cycle. `rd_data` always shows the stored word.
- R9: An operation and a compare in the same cycle are both applied: the flags are updated, the compare bits are updated, and the trap rule of R5 still holds.
- R10: Mask bit 0 (signaling compare request) does not affect the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the word |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Current status word |
| op_done | input | 1 | Operation completed; `op_exc` is valid |
| op_exc | input | 5 | Exceptions reported by the operation |
| cmp_valid | input | 1 | Compare result valid |
| cmp_rel | input | 2 | Relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_cond | input | 5 | Per-instruction condition mask |
| cmp_target | input | 3 | 0 selects the queue; 1..7 select a compare slot |
| round_sel | output | 4 | One-hot rounding select |
| flush_result | output | 1 | Flush denormal results to zero |
| flush_operand | output | 1 | Flush denormal operands to zero |
| assist_trap | output | 1 | One-cycle assist trap request |

## Verification
The hardest state to reach from the ports is the end of the compare queue. A bit pushed in at the head would take eleven queue compares to reach bit 15. The stimulus avoids this by using a software write to preload the word with bit 15 and the condition bit set. One queue compare then shows, in a single step, that the tail bit is dropped and that the old condition bit lands in the head. A second hard case is a cycle in which an operation, a compare and a software write all arrive together. The stimulus drives those strobes in the same cycle to show that the software write takes priority over both.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int WORD_W    = 32;
    localparam int EXC_W     = 5;
    localparam int ENA_LSB   = 0;
    localparam int FLAG_LSB  = 27;
    localparam int FLUSH_BIT = 5;
    localparam int RM_LSB    = 9;
    localparam int RM_W      = 2;
    localparam int COND_BIT  = 26;
    localparam int QUEUE_LSB = 15;
    localparam int SLOT0_BIT = 21;
    localparam int CMP_W     = COND_BIT - QUEUE_LSB + 1;
    localparam int MASK_W    = 5;
    localparam int TGT_W     = 3;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              trap;
    } fpsr_state_t;
endpackage

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode #(
    parameter int RMW = 2,
    localparam int NSEL = 1 << RMW
) (
    input  logic [RMW-1:0]  rm_code,
    input  logic            flush_bit,
    output logic [NSEL-1:0] round_sel,
    output logic            flush_result,
    output logic            flush_operand
);
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign round_sel[g] = (rm_code == RMW'(g));
    end
    assign flush_result  = flush_bit;
    assign flush_operand = flush_bit;
endmodule

// File: rtl/fpsr_exc_merge.sv
module fpsr_exc_merge #(
    parameter int EW = 5
) (
    input  logic          done,
    input  logic [EW-1:0] exc,
    input  logic [EW-1:0] enables,
    input  logic [EW-1:0] flags_in,
    output logic [EW-1:0] flags_out,
    output logic          trap_req
);
    logic [EW-1:0] raised;
    always_comb begin
        raised    = done ? exc : '0;
        flags_out = flags_in | raised;
        trap_req  = |(raised & enables);
    end
endmodule

// File: rtl/fpsr_cmp_update.sv
module fpsr_cmp_update #(
    parameter int FW    = 12,
    parameter int MW    = 5,
    parameter int TW    = 3,
    parameter int SLOT0 = 6
) (
    input  logic          valid,
    input  logic [1:0]    rel,
    input  logic [MW-1:0] cond,
    input  logic [TW-1:0] target,
    input  logic [FW-1:0] field_in,
    output logic [FW-1:0] field_out
);
    import fpsr_pkg::*;
    logic result;
    int   idx;

    always_comb begin
        unique case (rel_e'(rel))
            REL_GT:  result = cond[4];
            REL_LT:  result = cond[3];
            REL_EQ:  result = cond[2];
            default: result = cond[1];
        endcase
    end

    always_comb begin
        field_out = field_in;
        idx       = SLOT0 - (int'(target) - 1);
        if (valid) begin
            if (target != '0) begin
                if (idx >= 0 && idx < FW - 1) field_out[idx] = result;
            end else begin
                field_out[FW-3:0] = field_in[FW-2:1];
                field_out[FW-2]   = field_in[FW-1];
                field_out[FW-1]   = result;
            end
        end
    end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] rd_data,
    input  logic              op_done,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_rel,
    input  logic [MASK_W-1:0] cmp_cond,
    input  logic [TGT_W-1:0]  cmp_target,
    output logic [3:0]        round_sel,
    output logic              flush_result,
    output logic              flush_operand,
    output logic              assist_trap
);
    fpsr_state_t st_d, st_q;
    logic [EXC_W-1:0] flags_new;
    logic [CMP_W-1:0] cmp_new;
    logic             trap_req;

    fpsr_mode_decode #(.RMW(RM_W)) u_mode (
        .rm_code      (st_q.word[RM_LSB +: RM_W]),
        .flush_bit    (st_q.word[FLUSH_BIT]),
        .round_sel    (round_sel),
        .flush_result (flush_result),
        .flush_operand(flush_operand)
    );

    fpsr_exc_merge #(.EW(EXC_W)) u_exc (
        .done     (op_done),
        .exc      (op_exc),
        .enables  (st_q.word[ENA_LSB +: EXC_W]),
        .flags_in (st_q.word[FLAG_LSB +: EXC_W]),
        .flags_out(flags_new),
        .trap_req (trap_req)
    );

    fpsr_cmp_update #(
        .FW(CMP_W), .MW(MASK_W), .TW(TGT_W), .SLOT0(SLOT0_BIT - QUEUE_LSB)
    ) u_cmp (
        .valid    (cmp_valid),
        .rel      (cmp_rel),
        .cond     (cmp_cond),
        .target   (cmp_target),
        .field_in (st_q.word[QUEUE_LSB +: CMP_W]),
        .field_out(cmp_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (sw_we) begin
            st_d.word = sw_wdata;
        end else begin
            st_d.word[FLAG_LSB +: EXC_W]  = flags_new;
            st_d.word[QUEUE_LSB +: CMP_W] = cmp_new;
            st_d.trap                     = trap_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data     = st_q.word;
    assign assist_trap = st_q.trap;

    // R1
    round_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(round_sel) == 1);

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ((rd_data[31:27] & $past(rd_data[31:27])) == $past(rd_data[31:27])));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !cmp_valid && (!op_done || op_exc == '0)) |=> ($stable(rd_data) && !assist_trap));

    // R5
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        assist_trap |-> ($past(op_done) && !$past(sw_we) && ($past(op_exc & rd_data[4:0]) != '0)));

    // R6
    slot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_target != '0 && !sw_we && !op_done) |=>
        ($countones(rd_data ^ $past(rd_data)) <= 1));

    // R8
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (rd_data == $past(sw_wdata) && !assist_trap));
endmodule

// File: tb/fpsr_unit_test.sv
module fpsr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] rd_data;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [4:0]  cmp_cond = '0;
    logic [2:0]  cmp_target = '0;
    logic [3:0]  round_sel;
    logic        flush_result, flush_operand, assist_trap;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsr_unit uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        sw_we = 0; op_done = 0; cmp_valid = 0; op_exc = '0;
    endtask

    task automatic step();
        @(negedge clk);
        clear_in();
    endtask

    task automatic wr(logic [31:0] v);
        sw_we = 1; sw_wdata = v; step();
    endtask

    task automatic op(logic [4:0] e);
        op_done = 1; op_exc = e; step();
    endtask

    task automatic cmp(logic [1:0] rel, logic [4:0] cond, logic [2:0] tgt);
        cmp_valid = 1; cmp_rel = rel; cmp_cond = cond; cmp_target = tgt; step();
    endtask

    task automatic t_reset();
        chk("R8 reset word", rd_data, 32'h0);
        chk("R1 reset round", {28'h0, round_sel}, 32'h1);
        chk("R5 reset trap", {31'h0, assist_trap}, 32'h0);
    endtask

    task automatic t_round();
        for (int i = 0; i < 4; i++) begin
            wr(32'(i) << 9);
            chk("R1 round select", {28'h0, round_sel}, 32'h1 << i);
        end
    endtask

    task automatic t_flush();
        wr(32'h20);
        chk("R2 flush on", {30'h0, flush_result, flush_operand}, 32'h3);
        wr(32'h0);
        chk("R2 flush off", {30'h0, flush_result, flush_operand}, 32'h0);
    endtask

    task automatic t_sticky();
        wr(32'h0);
        op(5'b00101);
        chk("R3 flags or", rd_data, 32'h2800_0000);
        op(5'b10000);
        chk("R3 flags accumulate", rd_data, 32'hA800_0000);
    endtask

    task automatic t_trap();
        wr(32'h8);
        op(5'b01000);
        chk("R5 trap raised", {31'h0, assist_trap}, 32'h1);
        chk("R5 flag set", rd_data, 32'h4000_0008);
        step();
        chk("R5 trap one cycle", {31'h0, assist_trap}, 32'h0);
        op(5'b00001);
        chk("R5 disabled no trap", {31'h0, assist_trap}, 32'h0);
        chk("R5 flag only", rd_data, 32'h4800_0008);
        op(5'b00000);
        chk("R4 zero exc word", rd_data, 32'h4800_0008);
        chk("R4 zero exc trap", {31'h0, assist_trap}, 32'h0);
    endtask

    task automatic t_slot();
        wr(32'h0);
        cmp(2'd0, 5'b10000, 3'd3);
        chk("R6 slot y=3", rd_data, 32'h0008_0000);
        cmp(2'd2, 5'b00100, 3'd1);
        chk("R6 slot y=1", rd_data, 32'h0028_0000);
        wr(32'hFFFF_FFFF);
        cmp(2'd1, 5'b10111, 3'd7);
        chk("R6 slot y=7 clear", rd_data, 32'hFFFF_7FFF);
    endtask

    task automatic t_queue();
        wr(32'h0);
        cmp(2'd0, 5'b10000, 3'd0);
        chk("R7 queue first", rd_data, 32'h0400_0000);
        cmp(2'd1, 5'b10000, 3'd0);
        chk("R7 queue push", rd_data, 32'h0200_0000);
        cmp(2'd2, 5'b00100, 3'd0);
        chk("R7 queue shift", rd_data, 32'h0500_0000);
        wr(32'h0400_8000);
        cmp(2'd3, 5'b00010, 3'd0);
        chk("R7 queue tail drop", rd_data, 32'h0600_0000);
    endtask

    task automatic t_priority();
        wr(32'h0000_001F);
        sw_we = 1; sw_wdata = 32'h0000_0600;
        op_done = 1; op_exc = 5'b11111;
        cmp_valid = 1; cmp_rel = 2'd0; cmp_cond = 5'b10000; cmp_target = 3'd0;
        step();
        chk("R8 write wins", rd_data, 32'h0000_0600);
        chk("R8 no trap", {31'h0, assist_trap}, 32'h0);
        chk("R1 round down", {28'h0, round_sel}, 32'h8);
    endtask

    task automatic t_both();
        wr(32'h1);
        op_done = 1; op_exc = 5'b00001;
        cmp_valid = 1; cmp_rel = 2'd0; cmp_cond = 5'b10000; cmp_target = 3'd0;
        step();
        chk("R9 both applied", rd_data, 32'h0C00_0001);
        chk("R9 trap", {31'h0, assist_trap}, 32'h1);
    endtask

    task automatic t_signal();
        wr(32'h0);
        cmp(2'd0, 5'b10001, 3'd0);
        chk("R10 signaling same", rd_data, 32'h0400_0000);
        wr(32'h0);
        cmp(2'd0, 5'b00001, 3'd2);
        chk("R10 bit0 not stored", rd_data, 32'h0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round();
        t_flush();
        t_sticky();
        t_trap();
        t_slot();
        t_queue();
        t_priority();
        t_both();
        t_signal();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule